// File: doc/BRIEF.md
# Serial Port Register Bank with Receive Queue and Interrupts

This block is the programmer-visible side of a classic PC-style serial port. It has eight byte-wide registers at consecutive offsets, reached through a plain bus with a 3-bit address, read and write strobes, and 8-bit write and read data. A data write outside loop mode comes out as a one-cycle transmit strobe carrying the byte. Bytes from the host side come in through a valid-qualified input and go into a bounded receive queue. Software drains that queue through the data register.

Interrupt identification follows the familiar scheme. Bit 0 set means nothing is pending. A cause clears bit 0 and sets its own bit: 0x02 for transmit-empty, 0x04 for receive. Reading the identification register hands back its value ORed with 0xC0 and returns it to the idle value. Every raise of a cause produces a one-cycle interrupt pulse.

In loop mode, data writes fill the receive queue and host input is ignored. The modem-status register then reflects the modem-control outputs. The divisor latch is held for software but drives no bit timing.

Top module: `serial_regbank`

## Requirements
- R1: After reset, reads return: offset 0 (queue empty) 0x00, offset 1 0x00, offset 2 0xC1, offset 3 0x03, offset 4 0x08, offset 5 0x60, offset 6 0xB0, offset 7 0x00. The divisor resets to 12.
- R2: While line-control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. In that state, offset 0 neither pops the queue nor transmits, and offset 1 leaves interrupt enable unchanged.
- R3: A write to interrupt enable (offset 1, bit 7 of line control clear) keeps only the low four bits. Bit 0 enables the receive interrupt and bit 1 enables the transmit-empty interrupt.
- R4: Reading offset 2 returns the identification value ORed with 0xC0, and the value becomes 0x01 in the next cycle.
- R5: A data write with loop mode off (modem-control bit 4 clear) drives tx_valid high for one cycle, with the byte on tx_byte, in the cycle after the write. If transmit-empty interrupts are enabled, the same write also sets identification bit 1, clears bit 0, and pulses the interrupt.
- R6: A host byte with loop mode off enters the queue in arrival order and sets line-status bit 0 (offset 5 reads 0x61). With loop mode on, host bytes are ignored.
- R7: A byte accepted into the queue raises the receive cause (identification bit 2, plus an interrupt pulse) only when receive interrupts are enabled and bit 2 is not already set.
- R8: Reading data pops the oldest byte, or returns 0x00 when the queue is empty. The read clears identification bit 2, and the value returns to 0x01 if no cause remains. Line-status bit 0 clears once the last byte has been read.
- R9: With loop mode on, data writes go into the queue and never reach tx_valid. A write is dropped when the queue already holds 64 bytes, and host input arriving at a full queue is also dropped.
- R10: With loop mode on, offset 6 reads as follows: bit 5 follows modem-control bit 0, bit 4 follows bit 1, bit 6 follows bit 2, and bit 7 follows bit 3. With loop mode off it reads 0xB0.
- R11: When a data read and a host byte arrive in the same cycle, the pop happens first and the new byte is appended after it.
- R12: irq_pulse is high for exactly one cycle, in the cycle after each raise of a cause, and never when the matching enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| tx_byte | output | 8 | Transmitted byte |
| tx_valid | output | 1 | One-cycle strobe for tx_byte |
| rx_byte | input | 8 | Host-side received byte |
| rx_valid | input | 1 | Strobe for rx_byte |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
Directed sequences separate the mode-dependent meanings of offsets 0, 1 and 6: divisor selected or not, loop on or off. They also exercise the queue at its 64-byte limit and on an empty read, so a wrong drop rule or a missing zero on an empty read shows up as a wrong byte. A simultaneous read and host push, tried on both an empty and a non-empty queue, distinguishes pop-before-push ordering from the reverse. A pushed byte followed by another while the receive cause is still pending separates a raise-once interrupt from a raise-always one. Seeded random traffic then mixes writes to every offset, host bytes and reads, and a bench reference model predicts every read value, transmit strobe and interrupt pulse.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] OFS_DATA = 3'd0;
  localparam logic [AW-1:0] OFS_IEN  = 3'd1;
  localparam logic [AW-1:0] OFS_IID  = 3'd2;
  localparam logic [AW-1:0] OFS_LCTL = 3'd3;
  localparam logic [AW-1:0] OFS_MCTL = 3'd4;
  localparam logic [AW-1:0] OFS_LSTS = 3'd5;
  localparam logic [AW-1:0] OFS_MSTS = 3'd6;
  localparam logic [AW-1:0] OFS_SCR  = 3'd7;

  localparam logic [2:0]    IID_IDLE  = 3'b001;
  localparam logic [DW-1:0] IID_FILL  = 8'hC0;
  localparam logic [DW-1:0] LCTL_RST  = 8'h03;
  localparam logic [DW-1:0] MCTL_RST  = 8'h08;
  localparam logic [DW-1:0] MSTS_RST  = 8'hB0;
  localparam logic [DW-1:0] LSTS_BASE = 8'h60;
  localparam logic [15:0]   DIV_RST   = 16'd12;

  localparam int unsigned LCTL_DIVSEL = 7;
  localparam int unsigned MCTL_LOOP   = 4;
endpackage

// File: rtl/srb_rx_queue.sv
module srb_rx_queue #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8
) (
  input  logic                           clk,
  input  logic                           rst_ni,
  input  logic                           push,
  input  logic [W-1:0]                   push_data,
  input  logic                           pop,
  output logic                           accepted,
  output logic [W-1:0]                   head,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop_eff, full;

  always_comb begin
    full     = (cnt_q == CW'(DEPTH));
    pop_eff  = pop && (cnt_q != '0);
    // pop is applied before push, so a full queue can take a byte while popping
    accepted = push && (!full || pop_eff);
    rd_d     = rd_q;
    wr_d     = wr_q;
    cnt_d    = cnt_q;
    if (pop_eff) begin
      rd_d  = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_d - 1'b1;
    end
    if (accepted) begin
      wr_d  = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accepted) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (full && push && !pop) |=> (cnt_q == $past(cnt_q)));
  p_pop_push_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop && push && cnt_q != '0) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/srb_irq_ctrl.sv
module srb_irq_ctrl
  import serial_regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       iid_read,
  input  logic       data_read,
  input  logic       thr_evt,
  input  logic       rx_evt,
  input  logic [1:0] enables,
  output logic [2:0] iid,
  output logic       irq_pulse
);
  logic [2:0] iid_q, iid_d;
  logic       raise, irq_q;

  always_comb begin
    iid_d = iid_q;
    raise = 1'b0;
    if (iid_read) iid_d = IID_IDLE;
    if (data_read) begin
      iid_d[2] = 1'b0;
      if (iid_d == 3'b000) iid_d = IID_IDLE;
    end
    if (thr_evt && enables[1]) begin
      iid_d[0] = 1'b0;
      iid_d[1] = 1'b1;
      raise    = 1'b1;
    end
    if (rx_evt && enables[0] && !iid_d[2]) begin
      iid_d[0] = 1'b0;
      iid_d[2] = 1'b1;
      raise    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      iid_q <= IID_IDLE;
      irq_q <= 1'b0;
    end else begin
      iid_q <= iid_d;
      irq_q <= raise;
    end
  end

  assign iid       = iid_q;
  assign irq_pulse = irq_q;

  p_pulse_has_cause_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_q |-> !iid_q[0]);
  p_read_resets_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (iid_read && !thr_evt && !rx_evt) |=> (iid_q == IID_IDLE));
  p_no_repeat_rx_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_evt && iid_q[2] && !data_read && !iid_read && !thr_evt) |=> !irq_q);
endmodule

// File: rtl/srb_modem_view.sv
module srb_modem_view
  import serial_regbank_pkg::*;
(
  input  logic [7:0] mctl,
  output logic [7:0] msts
);
  logic loop;
  always_comb begin
    loop = mctl[MCTL_LOOP];
    if (loop) msts = {mctl[3], mctl[2], mctl[0], mctl[1], MSTS_RST[3:0]};
    else      msts = MSTS_RST;
  end
endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
  import serial_regbank_pkg::*;
#(
  parameter int unsigned QDEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   bus_addr,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  output logic [7:0]   tx_byte,
  output logic         tx_valid,
  input  logic [7:0]   rx_byte,
  input  logic         rx_valid,
  output logic         irq_pulse
);
  localparam int unsigned CW = $clog2(QDEPTH+1);

  logic [1:0]  rst_sync;
  logic        rst_ni;

  logic [7:0]  lctl_q, lctl_d, mctl_q, mctl_d, scr_q, scr_d;
  logic [3:0]  ien_q, ien_d;
  logic [15:0] div_q, div_d;
  logic [7:0]  txb_q, txb_d;
  logic        txv_q, txv_d;

  logic        divsel, loop, data_wr, data_rd, iid_rd, thr_evt;
  logic        q_push, q_acc;
  logic [7:0]  q_wdata, q_head, msts;
  logic [CW-1:0] q_cnt;
  logic [2:0]  iid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  always_comb begin
    divsel  = lctl_q[LCTL_DIVSEL];
    loop    = mctl_q[MCTL_LOOP];
    data_wr = bus_wr && (bus_addr == OFS_DATA) && !divsel;
    data_rd = bus_rd && (bus_addr == OFS_DATA) && !divsel;
    iid_rd  = bus_rd && (bus_addr == OFS_IID);
    thr_evt = data_wr && !loop;
    q_push  = loop ? data_wr : rx_valid;
    q_wdata = loop ? bus_wdata : rx_byte;
  end

  always_comb begin
    lctl_d = lctl_q;
    mctl_d = mctl_q;
    scr_d  = scr_q;
    ien_d  = ien_q;
    div_d  = div_q;
    txv_d  = thr_evt;
    txb_d  = thr_evt ? bus_wdata : txb_q;
    if (bus_wr) begin
      unique case (bus_addr)
        OFS_DATA: if (divsel) div_d[7:0]  = bus_wdata;
        OFS_IEN:  if (divsel) div_d[15:8] = bus_wdata;
                  else        ien_d       = bus_wdata[3:0];
        OFS_LCTL: lctl_d = bus_wdata;
        OFS_MCTL: mctl_d = bus_wdata;
        OFS_SCR:  scr_d  = bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lctl_q <= LCTL_RST;
      mctl_q <= MCTL_RST;
      scr_q  <= '0;
      ien_q  <= '0;
      div_q  <= DIV_RST;
      txv_q  <= 1'b0;
      txb_q  <= '0;
    end else begin
      lctl_q <= lctl_d;
      mctl_q <= mctl_d;
      scr_q  <= scr_d;
      ien_q  <= ien_d;
      div_q  <= div_d;
      txv_q  <= txv_d;
      txb_q  <= txb_d;
    end
  end

  srb_rx_queue #(.DEPTH(QDEPTH), .W(8)) u_queue (
    .clk(clk), .rst_ni(rst_ni), .push(q_push), .push_data(q_wdata),
    .pop(data_rd), .accepted(q_acc), .head(q_head), .count(q_cnt)
  );

  srb_irq_ctrl u_irq (
    .clk(clk), .rst_ni(rst_ni), .iid_read(iid_rd), .data_read(data_rd),
    .thr_evt(thr_evt), .rx_evt(q_acc), .enables(ien_q[1:0]),
    .iid(iid), .irq_pulse(irq_pulse)
  );

  srb_modem_view u_mview (.mctl(mctl_q), .msts(msts));

  always_comb begin
    unique case (bus_addr)
      OFS_DATA: bus_rdata = divsel ? div_q[7:0] : ((q_cnt != '0) ? q_head : 8'h00);
      OFS_IEN:  bus_rdata = divsel ? div_q[15:8] : {4'h0, ien_q};
      OFS_IID:  bus_rdata = {5'b0, iid} | IID_FILL;
      OFS_LCTL: bus_rdata = lctl_q;
      OFS_MCTL: bus_rdata = mctl_q;
      OFS_LSTS: bus_rdata = LSTS_BASE | {7'b0, (q_cnt != '0)};
      OFS_MSTS: bus_rdata = msts;
      OFS_SCR:  bus_rdata = scr_q;
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign tx_valid = txv_q;
  assign tx_byte  = txb_q;

  p_tx_cause_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_valid |-> $past(bus_wr && bus_addr == OFS_DATA && !divsel && !loop));
  p_tx_byte_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_valid |-> (tx_byte == $past(bus_wdata)));
  p_loop_rx_ignored_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (loop && rx_valid && !bus_wr) |=> (q_cnt <= $past(q_cnt)));
  p_divsel_keeps_ien_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (divsel && bus_wr && bus_addr == OFS_IEN) |=> $stable(ien_q));
endmodule

// File: tb/serial_regbank_test.sv
`timescale 1ns/1ps
module serial_regbank_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_rd, bus_wr, rx_valid;
  logic [7:0] bus_wdata, bus_rdata, tx_byte, rx_byte;
  logic       tx_valid, irq_pulse;

  always #2.5 clk = ~clk;

  serial_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .irq_pulse(irq_pulse)
  );

  int vectors = 0;
  int errors  = 0;

  logic [7:0]  mq[$];
  logic [2:0]  m_iid;
  logic [7:0]  m_lctl, m_mctl, m_scr;
  logic [3:0]  m_ien;
  logic [15:0] m_div;

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    logic dsel;
    dsel = m_lctl[7];
    case (a)
      3'd0: exp_read = dsel ? m_div[7:0] : ((mq.size() != 0) ? mq[0] : 8'h00);
      3'd1: exp_read = dsel ? m_div[15:8] : {4'h0, m_ien};
      3'd2: exp_read = {5'b0, m_iid} | 8'hC0;
      3'd3: exp_read = m_lctl;
      3'd4: exp_read = m_mctl;
      3'd5: exp_read = 8'h60 | {7'b0, mq.size() != 0};
      3'd6: exp_read = m_mctl[4] ? {m_mctl[3], m_mctl[2], m_mctl[0], m_mctl[1], 4'h0} : 8'hB0;
      default: exp_read = m_scr;
    endcase
  endfunction

  task automatic model_step(input logic rd, input logic wr, input logic [2:0] a, input logic [7:0] d,
                            input logic rv, input logic [7:0] rb,
                            output logic etx, output logic [7:0] etb, output logic eirq);
    logic dsel, lp, rxe;
    logic [3:0] ien_old;
    dsel = m_lctl[7]; lp = m_mctl[4]; ien_old = m_ien;
    etx = 0; etb = 8'h00; eirq = 0; rxe = 0;
    if (rd && a == 3'd2) m_iid = 3'b001;
    if (rd && a == 3'd0 && !dsel) begin
      if (mq.size() != 0) void'(mq.pop_front());
      m_iid[2] = 1'b0;
      if (m_iid == 3'b000) m_iid = 3'b001;
    end
    if (wr) begin
      case (a)
        3'd0: if (dsel) m_div[7:0] = d;
              else if (lp) begin if (mq.size() < 64) begin mq.push_back(d); rxe = 1; end end
              else begin
                etx = 1; etb = d;
                if (ien_old[1]) begin m_iid[0] = 0; m_iid[1] = 1; eirq = 1; end
              end
        3'd1: if (dsel) m_div[15:8] = d; else m_ien = d[3:0];
        3'd3: m_lctl = d;
        3'd4: m_mctl = d;
        3'd7: m_scr = d;
        default: ;
      endcase
    end
    if (rv && !lp && mq.size() < 64) begin mq.push_back(rb); rxe = 1; end
    if (rxe && ien_old[0] && !m_iid[2]) begin m_iid[0] = 0; m_iid[2] = 1; eirq = 1; end
  endtask

  task automatic step(input string tag, input logic rd, input logic wr, input logic [2:0] a,
                      input logic [7:0] d, input logic rv, input logic [7:0] rb);
    logic etx, eirq;
    logic [7:0] etb;
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d; rx_valid = rv; rx_byte = rb;
    #1;
    if (rd) chk(tag, "rdata", bus_rdata, exp_read(a));
    model_step(rd, wr, a, d, rv, rb, etx, etb, eirq);
    @(posedge clk); #1;
    bus_rd = 0; bus_wr = 0; rx_valid = 0;
    chk(tag, "tx_valid", {7'b0, tx_valid}, {7'b0, etx});
    if (etx) chk(tag, "tx_byte", tx_byte, etb);
    chk(tag, "irq_pulse", {7'b0, irq_pulse}, {7'b0, eirq});
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    step(tag, 1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00);
  endtask
  task automatic wr(input string tag, input logic [2:0] a, input logic [7:0] d);
    step(tag, 1'b0, 1'b1, a, d, 1'b0, 8'h00);
  endtask
  task automatic host(input string tag, input logic [7:0] b);
    step(tag, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 0; bus_addr = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0; rx_valid = 0; rx_byte = 0;
    m_iid = 3'b001; m_lctl = 8'h03; m_mctl = 8'h08; m_scr = 0; m_ien = 0; m_div = 16'd12;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 8; i++) rd("R1 reset", 3'(i));
    // divisor reset value
    wr("R2", 3'd3, 8'h83);
    rd("R1 div lo", 3'd0); rd("R1 div hi", 3'd1);
    wr("R2", 3'd0, 8'h34); wr("R2", 3'd1, 8'h12);
    rd("R2", 3'd0); rd("R2", 3'd1); rd("R2", 3'd5);
    wr("R2", 3'd3, 8'h03); rd("R2 ien kept", 3'd1);

    wr("R3", 3'd1, 8'hFF); rd("R3", 3'd1);

    wr("R5", 3'd0, 8'h41);
    rd("R4", 3'd2); rd("R4", 3'd2);

    host("R7", 8'h11); host("R7 no repeat", 8'h22);
    rd("R7", 3'd2); host("R7 after ack", 8'h33);
    rd("R6", 3'd5);
    rd("R8", 3'd0); rd("R8", 3'd2); rd("R8", 3'd0); rd("R8", 3'd0);
    rd("R8", 3'd5); rd("R8 empty", 3'd0);

    host("R11", 8'h44);
    step("R11", 1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 8'h55);
    rd("R11", 3'd5); rd("R11", 3'd0);
    step("R11 empty", 1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 8'h66);
    rd("R11", 3'd0); rd("R11", 3'd2);

    wr("R10", 3'd4, 8'h1F); rd("R10", 3'd6);
    wr("R10", 3'd4, 8'h15); rd("R10", 3'd6);
    host("R6 loop ignored", 8'h99); rd("R6 loop ignored", 3'd5);
    for (int i = 0; i < 65; i++) wr("R9 fill", 3'd0, 8'(i));
    host("R9 full", 8'hEE);
    rd("R9", 3'd5);
    for (int i = 0; i < 65; i++) rd("R9 drain", 3'd0);
    rd("R9", 3'd5);
    wr("R10", 3'd4, 8'h08); rd("R10", 3'd6);

    wr("R12", 3'd1, 8'h00); rd("R12", 3'd2);
    wr("R12", 3'd0, 8'h5A); host("R12", 8'h77); rd("R12", 3'd2); rd("R12", 3'd0);

    for (int n = 0; n < 4000; n++) begin
      int unsigned op;
      logic [2:0] a;
      logic [7:0] d;
      op = $urandom % 10;
      a  = 3'($urandom);
      d  = 8'($urandom);
      if (op < 4) host("rand", d);
      else if (op < 7) rd("rand", a);
      else if (op < 9) begin
        if (a == 3'd3 && ($urandom % 4) != 0) d[7] = 1'b0;
        wr("rand", a, d);
      end else step("rand R11", 1'b1, 1'b0, 3'd0, 8'h00, 1'b1, d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule